// File: doc/BRIEF.md
# Two-Level Interrupt Router

This block gathers up to 32 level-sensitive interrupt sources and steers each one to one of two processor request lines: a normal request and a fast request that the processor serves first. Software reaches the block over a plain 32-bit register bus with an address, a write strobe, write data and registered read data. Each level has four registers: a raw signal view, an enable mask, a write-only clear port for that mask, and a masked status view. Each source can be enabled at most in one of the two masks at a time.

The fast level is cascaded into both levels. The OR of fast status bits 31..1 drives the fast request. The same value also appears as source bit 0 in the signal and status views of both levels, so software can route the fast request onto the normal line as well. A write-only programming register raises programmed interrupts on source bit 1 of either level. These programmed interrupts bypass the enable masks.

Top module: `dual_intc`

## Requirements
- R1: After synchronous reset every readable register reads 0, both enable masks are empty, and `irq_o`, `fiq_o` and `rdata_o` are 0.
- R2: A write to an enable register (normal 0x008, fast 0x108) sets every bit that is 1 in the write data. Bits written as 0 keep their value.
- R3: A write to a clear register (normal 0x00C, fast 0x10C) clears every enable bit of that level that is 1 in the write data. No other bits change.
- R4: Setting an enable bit in one level clears the same bit in the other level's mask in that same cycle. No bit is ever set in both masks.
- R5: The signal register (normal 0x004, fast 0x104) shows the sources sampled one clock earlier on bits 31..1, and the fast cascade on bit 0. Input bit 0 is ignored. The status register (normal 0x000, fast 0x100) is signal AND enable.
- R6: `fiq_o` is the registered OR of fast status bits 31..1. It rises two clocks after a source enabled on the fast level is driven.
- R7: `irq_o` is the registered OR of all normal status bits, including the cascaded fast bit 0 when normal enable bit 0 is set.
- R8: A write to the programming register (0x010) loads write-data bit 2 into the programmed fast interrupt and bit 1 into the programmed normal interrupt. Each drives bit 1 of its level's signal and status registers, whatever the enable masks hold. Writing 0 removes it.
- R9: Read data appears one clock after the address. The clear registers, the programming register and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | 12 | Register byte address |
| we_i | input | 1 | Write strobe, one cycle per write |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data for the previous cycle's address |
| src_i | input | 32 | Level-sensitive interrupt sources; bit 0 is ignored |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The routing is tested with several patterns:
- A single source enabled only on the normal level shows that status masking works per level.
- A source enabled on the fast level tells the fast request apart from its cascade. The cascade shows on bit 0 of both signal views, and it reaches the normal line only once normal bit 0 is enabled.
- Two normal sources at once show that the request OR collects more than one bit.
- A drive on ignored input bit 0 shows that the reserved input has no effect.
- Programmed interrupts are raised with every mask bit 1 clear, which shows that they bypass the masks.
- Enable, clear and cross-level writes use overlapping bit patterns, so stickiness and mutual exclusion give different read-back values.

// File: rtl/intc_pkg.sv
package intc_pkg;

  localparam int DATA_W = 32;
  localparam int ADDR_W = 12;

  // register select inside one level group, from address bits 3:2
  typedef enum logic [1:0] {
    SEL_STA = 2'd0,
    SEL_SIG = 2'd1,
    SEL_EN  = 2'd2,
    SEL_CLR = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic     lvl_n;   // normal level group hit
    logic     lvl_f;   // fast level group hit
    logic     prog;    // programming register hit
    reg_sel_e sel;
  } dec_t;

endpackage

// File: rtl/intc_decode.sv
module intc_decode
  import intc_pkg::*;
#(
  parameter int              AW        = 12,
  parameter logic [AW-1:0]   BASE_N    = 12'h000,
  parameter logic [AW-1:0]   BASE_F    = 12'h100,
  parameter logic [AW-1:0]   PROG_ADDR = 12'h010
) (
  input  logic [AW-1:0] addr,
  output dec_t          dec
);

  localparam int GRP_LSB = 4;

  logic aligned;

  always_comb begin
    aligned   = (addr[1:0] == 2'b00);
    dec.lvl_n = aligned && (addr[AW-1:GRP_LSB] == BASE_N[AW-1:GRP_LSB]);
    dec.lvl_f = aligned && (addr[AW-1:GRP_LSB] == BASE_F[AW-1:GRP_LSB]);
    dec.prog  = (addr == PROG_ADDR);
    dec.sel   = reg_sel_e'(addr[3:2]);
  end

endmodule

// File: rtl/intc_level.sv
module intc_level #(
  parameter int DW           = 32,
  parameter bit SELF_CASCADE = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:1] src_hi,     // sampled sources, bit 0 position excluded
  input  logic          prog,       // programmed interrupt on bit 1
  input  logic          cascade_i,  // bit 0 value when not self-cascaded
  input  logic [DW-1:0] wdata,
  input  logic          en_we,      // set bits of own mask
  input  logic          clr_we,     // clear bits of own mask
  input  logic          kill_we,    // other level set its mask: clear same bits here
  output logic [DW-1:0] sig_o,
  output logic [DW-1:0] en_o,
  output logic [DW-1:0] sta_o,
  output logic          any_o       // OR of status bits DW-1..1
);

  logic [DW-1:1] sig_hi;
  logic [DW-1:1] sta_hi;
  logic [DW-1:0] en_q;
  logic          bit0;
  logic          unused_cascade;

  assign unused_cascade = cascade_i;

  // upper signal bits; programmed interrupt merges onto bit 1
  generate
    for (genvar i = 1; i < DW; i++) begin : g_sig
      if (i == 1) begin : g_prog
        assign sig_hi[i] = src_hi[i] | prog;
        assign sta_hi[i] = (src_hi[i] & en_q[i]) | prog;
      end else begin : g_plain
        assign sig_hi[i] = src_hi[i];
        assign sta_hi[i] = src_hi[i] & en_q[i];
      end
    end
  endgenerate

  assign any_o = |sta_hi;

  generate
    if (SELF_CASCADE) begin : g_self
      assign bit0 = any_o;
    end else begin : g_ext
      assign bit0 = cascade_i;
    end
  endgenerate

  assign sig_o = {sig_hi, bit0};
  assign sta_o = {sta_hi, bit0 & en_q[0]};
  assign en_o  = en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= '0;
    end else if (en_we) begin
      en_q <= en_q | wdata;
    end else if (clr_we) begin
      en_q <= en_q & ~wdata;
    end else if (kill_we) begin
      en_q <= en_q & ~wdata;
    end
  end

  // R2: bits written as 1 to the enable register are set afterwards
  p_en_set_r2: assert property (@(posedge clk) disable iff (rst)
    $past(en_we) |-> ((en_q & $past(wdata)) == $past(wdata)));

  // R2: without a clear or cross-level write, no enable bit falls
  p_en_sticky_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(clr_we) && !$past(kill_we)) |-> (($past(en_q) & ~en_q) == '0));

  // R3: bits named in a clear write are 0 afterwards
  p_clr_r3: assert property (@(posedge clk) disable iff (rst)
    ($past(clr_we) && !$past(en_we)) |-> ((en_q & $past(wdata)) == '0));

  // R4: the other level's set write removes the same bits here
  p_kill_r4: assert property (@(posedge clk) disable iff (rst)
    ($past(kill_we) && !$past(en_we)) |-> ((en_q & $past(wdata)) == '0));

endmodule

// File: rtl/intc_prog.sv
module intc_prog #(
  parameter int DW      = 32,
  parameter int BIT_N   = 1,
  parameter int BIT_F   = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  output logic          prog_n,
  output logic          prog_f
);

  logic [DW-1:0] unused_wdata;

  assign unused_wdata = wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      prog_n <= 1'b0;
      prog_f <= 1'b0;
    end else if (we) begin
      prog_n <= wdata[BIT_N];
      prog_f <= wdata[BIT_F];
    end
  end

  // R8: a programming write loads both request bits, zeros included
  p_prog_load_r8: assert property (@(posedge clk) disable iff (rst)
    $past(we) |-> (prog_f == $past(wdata[BIT_F]) && prog_n == $past(wdata[BIT_N])));

endmodule

// File: rtl/intc_rdmux.sv
module intc_rdmux
  import intc_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  dec_t          dec,
  input  logic [DW-1:0] sig_n,
  input  logic [DW-1:0] en_n,
  input  logic [DW-1:0] sta_n,
  input  logic [DW-1:0] sig_f,
  input  logic [DW-1:0] en_f,
  input  logic [DW-1:0] sta_f,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] sel_n;
  logic [DW-1:0] sel_f;
  logic [DW-1:0] nxt;

  always_comb begin
    unique case (dec.sel)
      SEL_STA: begin sel_n = sta_n; sel_f = sta_f; end
      SEL_SIG: begin sel_n = sig_n; sel_f = sig_f; end
      SEL_EN:  begin sel_n = en_n;  sel_f = en_f;  end
      default: begin sel_n = '0;    sel_f = '0;    end
    endcase
    if (dec.lvl_n)      nxt = sel_n;
    else if (dec.lvl_f) nxt = sel_f;
    else                nxt = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= nxt;
  end

  // R9: write-only and unmapped locations return zero
  p_wo_zero_r9: assert property (@(posedge clk) disable iff (rst)
    ($past(dec.sel == SEL_CLR) || !($past(dec.lvl_n) || $past(dec.lvl_f))) |-> (rdata == '0));

endmodule

// File: rtl/dual_intc.sv
module dual_intc
  import intc_pkg::*;
#(
  parameter int            DW        = intc_pkg::DATA_W,
  parameter int            AW        = intc_pkg::ADDR_W,
  parameter int            NSRC      = 32,
  parameter logic [AW-1:0] BASE_N    = 12'h000,
  parameter logic [AW-1:0] BASE_F    = 12'h100,
  parameter logic [AW-1:0] PROG_ADDR = 12'h010
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr_i,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic [NSRC-1:0] src_i,
  output logic          irq_o,
  output logic          fiq_o
);

  dec_t          dec;
  logic [DW-1:1] src_q;
  logic          unused_src0;
  logic          unused_any_n;

  logic          we_en_n, we_en_f, we_clr_n, we_clr_f, we_prog;
  logic          prog_n, prog_f;
  logic [DW-1:0] sig_n, en_n, sta_n;
  logic [DW-1:0] sig_f, en_f, sta_f;
  logic          any_f;

  assign unused_src0 = src_i[0];

  intc_decode #(
    .AW(AW), .BASE_N(BASE_N), .BASE_F(BASE_F), .PROG_ADDR(PROG_ADDR)
  ) u_dec (
    .addr (addr_i),
    .dec  (dec)
  );

  assign we_en_n  = we_i && dec.lvl_n && (dec.sel == SEL_EN);
  assign we_en_f  = we_i && dec.lvl_f && (dec.sel == SEL_EN);
  assign we_clr_n = we_i && dec.lvl_n && (dec.sel == SEL_CLR);
  assign we_clr_f = we_i && dec.lvl_f && (dec.sel == SEL_CLR);
  assign we_prog  = we_i && dec.prog;

  // sample sources; positions without a source stay 0
  generate
    for (genvar i = 1; i < DW; i++) begin : g_src
      if (i < NSRC) begin : g_live
        always_ff @(posedge clk) begin
          if (rst) src_q[i] <= 1'b0;
          else     src_q[i] <= src_i[i];
        end
      end else begin : g_tied
        assign src_q[i] = 1'b0;
      end
    end
  endgenerate

  intc_prog #(.DW(DW)) u_prog (
    .clk    (clk),
    .rst    (rst),
    .we     (we_prog),
    .wdata  (wdata_i),
    .prog_n (prog_n),
    .prog_f (prog_f)
  );

  intc_level #(.DW(DW), .SELF_CASCADE(1'b1)) u_lvl_f (
    .clk       (clk),
    .rst       (rst),
    .src_hi    (src_q),
    .prog      (prog_f),
    .cascade_i (1'b0),
    .wdata     (wdata_i),
    .en_we     (we_en_f),
    .clr_we    (we_clr_f),
    .kill_we   (we_en_n),
    .sig_o     (sig_f),
    .en_o      (en_f),
    .sta_o     (sta_f),
    .any_o     (any_f)
  );

  intc_level #(.DW(DW), .SELF_CASCADE(1'b0)) u_lvl_n (
    .clk       (clk),
    .rst       (rst),
    .src_hi    (src_q),
    .prog      (prog_n),
    .cascade_i (any_f),
    .wdata     (wdata_i),
    .en_we     (we_en_n),
    .clr_we    (we_clr_n),
    .kill_we   (we_en_f),
    .sig_o     (sig_n),
    .en_o      (en_n),
    .sta_o     (sta_n),
    .any_o     (unused_any_n)
  );

  intc_rdmux #(.DW(DW)) u_rd (
    .clk   (clk),
    .rst   (rst),
    .dec   (dec),
    .sig_n (sig_n),
    .en_n  (en_n),
    .sta_n (sta_n),
    .sig_f (sig_f),
    .en_f  (en_f),
    .sta_f (sta_f),
    .rdata (rdata_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o <= 1'b0;
      fiq_o <= 1'b0;
    end else begin
      irq_o <= |sta_n;
      fiq_o <= any_f;
    end
  end

  // R4: no source enabled on both levels
  p_excl_r4: assert property (@(posedge clk) disable iff (rst)
    ((en_n & en_f) == '0));

  // R6: a fast request needs a fast enable or a programmed fast interrupt
  p_fiq_src_r6: assert property (@(posedge clk) disable iff (rst)
    fiq_o |-> ($past(en_f) != '0 || $past(prog_f)));

  // R7: a normal request needs a normal enable or a programmed normal interrupt
  p_irq_src_r7: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> ($past(en_n) != '0 || $past(prog_n)));

  // R8: a programmed fast interrupt raises the fast line regardless of masks
  p_prog_nomask_r8: assert property (@(posedge clk) disable iff (rst)
    prog_f |=> fiq_o);

endmodule

// File: tb/test_dual_intc.sv
`timescale 1ns/1ps
module test_dual_intc;

  localparam int DW = 32;
  localparam int AW = 12;

  localparam logic [AW-1:0] A_STA_N = 12'h000;
  localparam logic [AW-1:0] A_SIG_N = 12'h004;
  localparam logic [AW-1:0] A_EN_N  = 12'h008;
  localparam logic [AW-1:0] A_CLR_N = 12'h00C;
  localparam logic [AW-1:0] A_PROG  = 12'h010;
  localparam logic [AW-1:0] A_STA_F = 12'h100;
  localparam logic [AW-1:0] A_SIG_F = 12'h104;
  localparam logic [AW-1:0] A_EN_F  = 12'h108;
  localparam logic [AW-1:0] A_CLR_F = 12'h10C;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] addr_i = '0;
  logic          we_i = 1'b0;
  logic [DW-1:0] wdata_i = '0;
  logic [DW-1:0] rdata_o;
  logic [DW-1:0] src_i = '0;
  logic          irq_o;
  logic          fiq_o;

  int tests_run = 0;
  int tests_failed = 0;
  int cyc = 0;
  bit done = 1'b0;

  typedef struct {
    int          kind;   // 0 read data, 1 irq_o, 2 fiq_o
    logic [31:0] exp;
    int          due;
    string       tag;
  } sb_item_t;

  sb_item_t sbq[$];

  always #2 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  dual_intc i_dual_intc (
    .clk     (clk),
    .rst     (rst),
    .addr_i  (addr_i),
    .we_i    (we_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .src_i   (src_i),
    .irq_o   (irq_o),
    .fiq_o   (fiq_o)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests_run++;
    if (!ok) begin
      tests_failed++;
      $display("FIT %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: compare scoreboard items as the design produces results
  always @(negedge clk) begin
    while (sbq.size() > 0 && sbq[0].due <= cyc) begin
      automatic sb_item_t it = sbq.pop_front();
      automatic logic [31:0] act;
      case (it.kind)
        0:       act = rdata_o;
        1:       act = {31'd0, irq_o};
        default: act = {31'd0, fiq_o};
      endcase
      check(it.due == cyc && act === it.exp, it.tag, act, it.exp);
    end
  end

  task automatic push(input int kind, input logic [31:0] exp, input int dly, input string tag);
    sb_item_t it;
    it.kind = kind;
    it.exp  = exp;
    it.due  = cyc + dly;
    it.tag  = tag;
    sbq.push_back(it);
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [31:0] exp, input string tag);
    addr_i = a;
    push(0, exp, 1, tag);
    @(negedge clk);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    addr_i  = a;
    wdata_i = d;
    we_i    = 1'b1;
    @(negedge clk);
    we_i    = 1'b0;
    wdata_i = '0;
  endtask

  task automatic set_src(input logic [31:0] v);
    src_i = v;
    @(negedge clk);
  endtask

  task automatic lines(input bit irq, input bit fiq, input string tag);
    push(1, {31'd0, irq}, 1, tag);
    push(2, {31'd0, fiq}, 1, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests_run++;
      tests_failed++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: request lines low while held in reset
    check(irq_o === 1'b0, "R1 irq_o in reset", {31'd0, irq_o}, 32'd0);
    check(fiq_o === 1'b0, "R1 fiq_o in reset", {31'd0, fiq_o}, 32'd0);
    check(rdata_o === '0, "R1 rdata_o in reset", rdata_o, 32'd0);
    rst = 1'b0;
    @(negedge clk);

    // R1: every readable register empty after reset
    rd(A_STA_N, 32'h0, "R1 normal status");
    rd(A_SIG_N, 32'h0, "R1 normal signal");
    rd(A_EN_N,  32'h0, "R1 normal enable");
    rd(A_STA_F, 32'h0, "R1 fast status");
    rd(A_SIG_F, 32'h0, "R1 fast signal");
    rd(A_EN_F,  32'h0, "R1 fast enable");

    // R2: set-only enable writes
    wr(A_EN_N, 32'h0000_00F0);
    rd(A_EN_N, 32'h0000_00F0, "R2 enable set");
    wr(A_EN_N, 32'h0000_0000);
    rd(A_EN_N, 32'h0000_00F0, "R2 zero write keeps bits");
    wr(A_EN_N, 32'h0000_0100);
    rd(A_EN_N, 32'h0000_01F0, "R2 enable accumulates");

    // R3: clear port
    wr(A_CLR_N, 32'h0000_0030);
    rd(A_EN_N, 32'h0000_01C0, "R3 clear removes named bits");

    // R4: cross-level exclusion in both directions
    wr(A_EN_F, 32'h0000_0140);
    rd(A_EN_F, 32'h0000_0140, "R4 fast enable set");
    rd(A_EN_N, 32'h0000_0080, "R4 fast set clears normal bits");
    wr(A_EN_N, 32'h0000_0040);
    rd(A_EN_N, 32'h0000_00C0, "R4 normal enable set");
    rd(A_EN_F, 32'h0000_0100, "R4 normal set clears fast bit");

    // R5: single normal source, masked per level
    set_src(32'h0000_0080);
    lines(1'b1, 1'b0, "R5 normal source lines");
    rd(A_SIG_N, 32'h0000_0080, "R5 normal signal");
    rd(A_STA_N, 32'h0000_0080, "R5 normal status");
    rd(A_SIG_F, 32'h0000_0080, "R5 fast signal unmasked view");
    rd(A_STA_F, 32'h0000_0000, "R5 fast status masked");

    // R6: fast source and its cascade
    set_src(32'h0000_0100);
    lines(1'b0, 1'b1, "R6 fast source lines");
    rd(A_SIG_F, 32'h0000_0101, "R6 fast signal with cascade bit0");
    rd(A_STA_F, 32'h0000_0100, "R6 fast status");
    rd(A_SIG_N, 32'h0000_0101, "R6 normal signal sees cascade");
    rd(A_STA_N, 32'h0000_0000, "R6 normal status masked");

    // R7: cascade onto normal line once normal bit0 enabled
    wr(A_EN_N, 32'h0000_0001);
    lines(1'b1, 1'b1, "R7 cascade on normal line");
    rd(A_STA_N, 32'h0000_0001, "R7 normal status cascade bit");

    // R7: all low, then two normal sources together
    set_src(32'h0000_0000);
    lines(1'b0, 1'b0, "R7 idle lines");
    set_src(32'h0000_00C0);
    lines(1'b1, 1'b0, "R7 two normal sources");
    rd(A_STA_N, 32'h0000_00C0, "R7 normal status two bits");

    // R5: input bit 0 ignored
    set_src(32'h0000_0001);
    lines(1'b0, 1'b0, "R5 input bit0 ignored lines");
    rd(A_SIG_N, 32'h0000_0000, "R5 input bit0 ignored signal");

    // R8: programmed interrupts bypass the masks (bit1 disabled on both)
    set_src(32'h0000_0000);
    wr(A_PROG, 32'h0000_0004);
    lines(1'b1, 1'b1, "R8 programmed fast lines");
    rd(A_SIG_F, 32'h0000_0003, "R8 programmed fast signal");
    rd(A_STA_F, 32'h0000_0002, "R8 programmed fast status");
    rd(A_STA_N, 32'h0000_0001, "R8 cascade to normal status");
    wr(A_PROG, 32'h0000_0002);
    lines(1'b1, 1'b0, "R8 programmed normal lines");
    rd(A_SIG_N, 32'h0000_0002, "R8 programmed normal signal");
    rd(A_STA_N, 32'h0000_0002, "R8 programmed normal status");
    rd(A_SIG_F, 32'h0000_0000, "R8 programmed fast removed");
    wr(A_PROG, 32'h0000_0000);
    lines(1'b0, 1'b0, "R8 programmed cleared");

    // R9: write-only and unmapped addresses read zero
    rd(A_CLR_N, 32'h0, "R9 normal clear reads zero");
    rd(A_CLR_F, 32'h0, "R9 fast clear reads zero");
    rd(A_PROG,  32'h0, "R9 programming reads zero");
    rd(12'h200, 32'h0, "R9 unmapped reads zero");

    // R3: fast clear leaves normal mask alone
    wr(A_CLR_F, 32'hFFFF_FFFF);
    rd(A_EN_F, 32'h0, "R3 fast clear all");
    rd(A_EN_N, 32'h0000_00C1, "R3 normal mask untouched");

    repeat (3) @(negedge clk);
    check(sbq.size() == 0, "scoreboard drained", sbq.size(), 32'd0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end

endmodule